// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances on a single-cycle `tick` input (the counting clock, qualified against the system clock) and is steered by a `gate` level input. A 3-bit mode code picks one of the counting behaviours: one-shot counting that wraps freely, periodic rate generation, and square-wave generation. One waveform output is derived from the count. The current count is always visible on `count_o`, so a bus wrapper elsewhere can latch it.

A host first writes a mode with `cfg_we`, which parks the channel. It then writes a count with `load_we`, which arms the channel and starts the sequence at once. A written value of zero stands for 65536, so periods run from 1 to 65536 ticks. In modes 1, 2, 3 and 5, a rising edge on `gate` restarts the sequence from the programmed value. In the gated modes, holding `gate` low freezes the count.

Top module: `interval_counter`

## Requirements
- R1: A synchronous active-high `rst` leaves `count_o` at 0, `out_o` low, the mode at 0 and the channel unarmed.
- R2: `load_we` stores `load_val` as the programmed value, puts it on `count_o` on the next cycle and arms the channel. Value 0 acts as 65536: the periodic modes take 65536 ticks per period. A load takes priority over a gate edge and a tick in the same cycle.
- R3: In modes 0 and 4, each tick lowers the count by one while `gate` is high. The count wraps from 0 to 65535 with no reload.
- R4: In mode 0, `out_o` goes low on load and goes high on the tick that brings the count to 0. It stays high through later wraps until the next load or mode write.
- R5: In modes 1 and 5, each tick lowers the count by one whatever the level of `gate`. The count wraps with no reload. `out_o` is low exactly while a tick has left the count at 0.
- R6: In mode 2, and in codes 6 and 7, each tick lowers the count by one. A tick at count 1 reloads the programmed value. `out_o` is low for the one tick period in which the count equals 1.
- R7: In mode 3, each tick lowers the count by two. A tick at count 1 or 2 reloads the programmed value and inverts `out_o`.
- R8: In modes 1, 2, 3, 5, 6 and 7, a rising edge of `gate` on an armed channel reloads the programmed value into the count and drives `out_o` high.
- R9: In modes 0, 2, 3, 4, 6 and 7, ticks while `gate` is low leave the count and `out_o` unchanged.
- R10: `cfg_we` sets the mode from `cfg_mode` and stops counting until the next load. It drives `out_o` low for mode 0 and high for any other mode.
- R11: A cycle with no tick, no load, no mode write and no gate rising edge changes neither `count_o` nor `out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle counting pulse |
| gate | input | 1 | Gate level; rising edge restarts in modes 1, 2, 3, 5, 6, 7 |
| cfg_we | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code 0..7 |
| load_we | input | 1 | Count load strobe |
| load_val | input | 16 | Count value, 0 meaning 65536 |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Waveform output |

## Verification
The count and the output are both registered on the ports, so a corrupted internal value shows at `count_o` or `out_o` one cycle after the step that produced it. The exception is the stored programmed value. It stays hidden until the next reload: the end of a period in mode 2 or 3, or a gate restart. The bench therefore forces many short periods and gate edges, so a bad stored value appears within a few ticks. An error in the sticky mode 0 output appears only after a wrap, so the directed part runs mode 0 through its wrap past zero.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int MODE_W = 3;

    // Modes whose decrement is suspended while gate is low.
    function automatic logic ic_gated(input logic [MODE_W-1:0] m);
        return !(m == 3'd1 || m == 3'd5);
    endfunction

    // Modes in which a gate rising edge restarts the sequence.
    function automatic logic ic_restarts(input logic [MODE_W-1:0] m);
        return !(m == 3'd0 || m == 3'd4);
    endfunction

    // Modes that wrap freely without reload.
    function automatic logic ic_oneshot(input logic [MODE_W-1:0] m);
        return (m == 3'd0 || m == 3'd1 || m == 3'd4 || m == 3'd5);
    endfunction
endpackage

// File: rtl/ic_edge.sv
module ic_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/ic_step.sv
module ic_step
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  reload,
    input  logic              out,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic              out_nx
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);
    localparam logic [CNT_W-1:0] ZERO = '0;

    always_comb begin
        cnt_nx = cnt;
        out_nx = out;
        if (ic_oneshot(mode)) begin
            cnt_nx = cnt - ONE;
            if (mode == 3'd0) out_nx = out | (cnt_nx == ZERO);
            else              out_nx = (cnt_nx != ZERO);
        end else if (mode == 3'd3) begin
            if (cnt == ONE || cnt == TWO) begin
                cnt_nx = reload;
                out_nx = ~out;
            end else begin
                cnt_nx = cnt - TWO;
            end
        end else begin
            if (cnt == ONE) cnt_nx = reload;
            else            cnt_nx = cnt - ONE;
            out_nx = (cnt_nx != ONE);
        end
    end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import ic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              load_we,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count_o,
    output logic              out_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  cnt;
        logic              out;
        logic              armed;
    } state_t;

    state_t st_d, st_q;
    logic gate_rise;
    logic restart, advance;
    logic [CNT_W-1:0] step_cnt;
    logic step_out;

    ic_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (gate),
        .rise (gate_rise)
    );

    ic_step #(.CNT_W(CNT_W)) u_step (
        .mode   (st_q.mode),
        .cnt    (st_q.cnt),
        .reload (st_q.reload),
        .out    (st_q.out),
        .cnt_nx (step_cnt),
        .out_nx (step_out)
    );

    always_comb begin
        restart = st_q.armed && gate_rise && ic_restarts(st_q.mode);
        advance = st_q.armed && tick && (gate || !ic_gated(st_q.mode));
        st_d = st_q;
        if (cfg_we) begin
            st_d.mode  = cfg_mode;
            st_d.armed = 1'b0;
            st_d.out   = (cfg_mode != 3'd0);
        end
        if (load_we) begin
            st_d.reload = load_val;
            st_d.cnt    = load_val;
            st_d.armed  = 1'b1;
            st_d.out    = (st_d.mode != 3'd0);
        end else if (!cfg_we && restart) begin
            st_d.cnt = st_q.reload;
            st_d.out = 1'b1;
        end else if (!cfg_we && advance) begin
            st_d.cnt = step_cnt;
            st_d.out = step_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign out_o   = st_q.out;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !out_o && st_q.mode == '0));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_we |=> count_o == $past(load_val));

    // R7
    square_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && st_q.mode == 3'd3 && !load_we && !cfg_we && !restart
         && st_q.cnt > CNT_W'(2))
        |=> count_o == CNT_W'($past(st_q.cnt) - CNT_W'(2)));

    // R4
    mode0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == 3'd0 && out_o && !load_we && !cfg_we) |=> out_o);

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate && ic_gated(st_q.mode) && !load_we && !cfg_we)
        |=> ($stable(count_o) && $stable(out_o)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_we && !cfg_we && !gate_rise)
        |=> ($stable(count_o) && $stable(out_o)));
endmodule

// File: tb/interval_counter_test.sv
`timescale 1ns/1ps
module interval_counter_test;
    logic clk = 0;
    logic rst, tick, gate, cfg_we, load_we;
    logic [2:0] cfg_mode;
    logic [15:0] load_val;
    logic [15:0] count_o;
    logic out_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench reference state
    logic [2:0]  m_mode;
    logic [15:0] m_rel, m_cnt;
    logic        m_out, m_arm, m_gprev;

    always #5 clk = ~clk;

    interval_counter uut (
        .clk(clk), .rst(rst), .tick(tick), .gate(gate),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .load_we(load_we), .load_val(load_val),
        .count_o(count_o), .out_o(out_o)
    );

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0, 3'd4: return "R3";
            3'd1, 3'd5: return "R5";
            3'd3:       return "R7";
            default:    return "R6";
        endcase
    endfunction

    task automatic model_step();
        bit rise, rst_ok, gated;
        rise  = gate && !m_gprev;
        gated = !(m_mode == 1 || m_mode == 5);
        if (rst) begin
            m_mode = 0; m_rel = 0; m_cnt = 0; m_out = 0; m_arm = 0; m_gprev = 0;
            return;
        end
        rst_ok = 1;
        if (cfg_we) begin
            m_mode = cfg_mode; m_arm = 0; m_out = (cfg_mode != 0);
        end
        if (load_we) begin
            m_rel = load_val; m_cnt = load_val; m_arm = 1; m_out = (m_mode != 0);
        end else if (!cfg_we && m_arm && rise && !(m_mode == 0 || m_mode == 4)) begin
            m_cnt = m_rel; m_out = 1;
        end else if (!cfg_we && m_arm && tick && (gate || !gated)) begin
            case (m_mode)
                3'd0: begin m_cnt = m_cnt - 1; if (m_cnt == 0) m_out = 1; end
                3'd1, 3'd4, 3'd5: begin m_cnt = m_cnt - 1; m_out = (m_cnt != 0); end
                3'd3: begin
                    if (m_cnt == 1 || m_cnt == 2) begin m_cnt = m_rel; m_out = !m_out; end
                    else m_cnt = m_cnt - 2;
                end
                default: begin
                    m_cnt = (m_cnt == 1) ? m_rel : m_cnt - 1;
                    m_out = (m_cnt != 1);
                end
            endcase
        end
        m_gprev = gate && rst_ok;
    endtask

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, {out_o, count_o}, {m_out, m_cnt});
        cfg_we = 0; load_we = 0;
    endtask

    task automatic set_mode(input logic [2:0] m, input string tag);
        cfg_we = 1; cfg_mode = m; tick = 0;
        cyc(tag);
    endtask

    task automatic load(input logic [15:0] v, input string tag);
        load_we = 1; load_val = v; tick = 0;
        cyc(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            cyc(tag);
        end
        tick = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        rst = 1; tick = 0; gate = 0; cfg_we = 0; load_we = 0; cfg_mode = 0; load_val = 0;
        m_gprev = 0;
        @(negedge clk);
        cyc("R1");
        cyc("R1");
        check("R1", {out_o, count_o}, 17'h0);
        rst = 0;

        // mode 0: load, count to zero, wrap, sticky output
        gate = 1;
        set_mode(3'd0, "R10");
        check("R10", {16'h0, out_o}, 17'h0);
        load(16'd3, "R2");
        check("R2", {out_o, count_o}, {1'b0, 16'd3});
        ticks(3, "R4");
        check("R4", {out_o, count_o}, {1'b1, 16'd0});
        ticks(1, "R3");
        check("R3", {out_o, count_o}, {1'b1, 16'hFFFF});
        gate = 0;
        ticks(2, "R9");
        check("R9", {16'h0, count_o == 16'hFFFF}, 17'h1);
        gate = 1;
        cyc("R11");
        cyc("R11");
        check("R11", {out_o, count_o}, {1'b1, 16'hFFFF});

        // mode 3: step by two, toggle at reload
        set_mode(3'd3, "R10");
        load(16'd5, "R2");
        ticks(2, "R7");
        check("R7", {out_o, count_o}, {1'b1, 16'd1});
        ticks(1, "R7");
        check("R7", {out_o, count_o}, {1'b0, 16'd5});

        // mode 2 with gate restart
        set_mode(3'd2, "R10");
        load(16'd4, "R2");
        ticks(3, "R6");
        check("R6", {out_o, count_o}, {1'b0, 16'd1});
        gate = 0;
        cyc("R9");
        gate = 1;
        cyc("R8");
        check("R8", {out_o, count_o}, {1'b1, 16'd4});

        // mode 1 counts with gate low
        set_mode(3'd1, "R10");
        load(16'd2, "R2");
        gate = 0;
        ticks(2, "R5");
        check("R5", {out_o, count_o}, {1'b0, 16'd0});
        ticks(1, "R5");
        check("R5", {out_o, count_o}, {1'b1, 16'hFFFF});

        // mode 7 behaves as a rate generator
        gate = 1;
        set_mode(3'd7, "R6");
        load(16'd2, "R6");
        ticks(2, "R6");
        check("R6", {out_o, count_o}, {1'b1, 16'd2});

        // constrained random
        for (int i = 0; i < 20000; i++) begin
            tick = ($urandom % 2) == 0;
            if (($urandom % 8) == 0) gate = !gate;
            if (($urandom % 150) == 0) begin cfg_we = 1; cfg_mode = 3'($urandom % 8); end
            if (($urandom % 60) == 0) begin
                load_we = 1;
                load_val = (($urandom % 10) == 0) ? 16'($urandom) : 16'($urandom % 12);
            end
            cyc(tag_of(m_mode));
        end

        // zero load gives a 65536-tick period
        gate = 1;
        set_mode(3'd2, "R10");
        load(16'd0, "R2");
        ticks(65535, "R2");
        check("R2", {out_o, count_o}, {1'b0, 16'd1});
        ticks(1, "R2");
        check("R2", {out_o, count_o}, {1'b1, 16'd0});

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule